// File: doc/BRIEF.md
# Delta-Correlation Markov Prefetcher

This block watches a stream of load events (a program-counter value and the address the load touched) and predicts which addresses that load will need next. A small history table, indexed by a fold of the PC, keeps for each load the low bits of its last address and its three most recent address deltas. Those three deltas are hashed into a shared pattern table. Each pattern-table entry holds two candidate next deltas, and each candidate has its own one-bit confidence flag. The confidence therefore belongs to a transition between delta histories, not to a particular load, so two loads that show the same delta pattern train and use the same entries.

Each accepted event first trains the pattern entry for the load's previous history with the delta just observed. The event then starts a walk from its new history. At every step the walk emits up to two prefetch addresses, one for each confident candidate, and then moves along one predicted delta. The walk lasts at most a fixed number of steps, four by default, so one event yields at most eight addresses. Addresses leave one per cycle. While a walk is running the block does not accept new events.

Top module: `delta_markov_prefetcher`

## Requirements
- R1: While reset is asserted, and for two cycles after it is released, `ev_ready` is low and `pf_valid` is low. After that, with no event offered, `ev_ready` is high and `pf_valid` is low. Every table entry starts empty.
- R2: An event is accepted in a cycle where `ev_valid` and `ev_ready` are both high. The history slot is the XOR of all 7-bit chunks of `ev_pc`, taken from bit 0 upward with zero fill at the top, so PCs that fold to the same value share a slot. The first event into an empty slot records its address and sets its history to three zero deltas. It trains nothing and emits no prefetch, and `ev_ready` is high again in the next cycle.
- R3: For an event into a filled slot, the observed delta is the low 16 bits of `ev_addr` minus the stored low 16 bits, modulo 2^16. The new history is {observed, previous newest, previous middle}.
- R4: The pattern index is 10 bits wide. Each history delta is zero-extended or truncated to 20 bits. Its two 10-bit halves are XORed, and the result is shifted left by the delta's age (0 for the newest, 2 for the oldest), keeping 10 bits. The three results are XORed together.
- R5: Training works on the entry of the previous history. An empty entry gets both slots set to the observed delta, with both flags clear. If slot 0 equals the observed delta, flag 0 is set; otherwise, if slot 1 equals it, flag 1 is set.
- R6: If neither slot matches, the observed delta overwrites slot 0 when flag 0 is clear, or slot 1 otherwise, and the flag of the written slot is cleared.
- R7: A walk step looks up the entry of the current walk history. It emits base + sign-extended slot 0 delta if flag 0 is set, and then base + sign-extended slot 1 delta if flag 1 is set. The base starts at the event's full address.
- R8: After a step, the walk follows slot 0 if flag 0 is set, else slot 1 if flag 1 is set. Following a slot adds that delta to the base and shifts it into the walk history. The walk stops when the entry is empty, when neither flag is set, or after 4 steps, so it emits at most 8 addresses.
- R9: `ev_ready` is low from the cycle after a walk starts until the walk ends. No prefetch is emitted while `ev_ready` is high.
- R10: A load whose history matches a pattern another load has trained gets predictions from that pattern as soon as its own three-delta history forms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_valid | input | 1 | Load event offered |
| ev_ready | output | 1 | Block can take an event this cycle |
| ev_pc | input | PC_W | PC of the load |
| ev_addr | input | ADDR_W | Address referenced by the load |
| pf_valid | output | 1 | Prefetch address valid this cycle |
| pf_addr | output | ADDR_W | Predicted prefetch address |

## Verification
A load with a constant positive stride shows whether confidence builds only after a transition repeats, and whether the walk then follows slot 0 for its full depth. A second load with the same stride tells shared, transition-level confidence apart from per-load state. Alias PCs show that slots are selected by the PC fold. Alternating deltas and a pattern whose fixed history is followed by changing deltas exercise slot 1, the choice of which slot to overwrite, and which slot the walk follows. Falling addresses and jumps wider than 16 bits expose errors in sign extension and in delta truncation.

// File: rtl/mkv_pkg.sv
package mkv_pkg;

  typedef enum logic [1:0] {
    W_IDLE  = 2'd0,
    W_SLOT0 = 2'd1,
    W_SLOT1 = 2'd2
  } walk_state_e;

endpackage

// File: rtl/mkv_hash.sv
module mkv_hash #(
  parameter int DELTA_W = 16,
  parameter int IDX_W   = 10
) (
  input  logic [2:0][DELTA_W-1:0] hist,
  output logic [IDX_W-1:0]        idx
);
  localparam int SEL_W = 2 * IDX_W;

  logic [2:0][IDX_W-1:0] part;

  for (genvar a = 0; a < 3; a++) begin : g_age
    logic [SEL_W-1:0] sel;
    logic [IDX_W-1:0] fold;
    assign sel     = SEL_W'(hist[a]);
    assign fold    = sel[IDX_W-1:0] ^ sel[SEL_W-1:IDX_W];
    assign part[a] = fold << a;
  end

  assign idx = part[0] ^ part[1] ^ part[2];
endmodule

// File: rtl/mkv_hist_table.sv
module mkv_hist_table #(
  parameter int IDX_W   = 7,
  parameter int DELTA_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [IDX_W-1:0]        idx,
  output logic                    rd_hit,
  output logic [DELTA_W-1:0]      rd_last,
  output logic [2:0][DELTA_W-1:0] rd_hist,
  input  logic                    wr_en,
  input  logic [DELTA_W-1:0]      wr_last,
  input  logic [2:0][DELTA_W-1:0] wr_hist
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0]        vld_q;
  logic [DELTA_W-1:0]        last_q [ENTRIES];
  logic [2:0][DELTA_W-1:0]   hist_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_vld
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             vld_q[g] <= 1'b0;
      else if (wr_en && idx == IDX_W'(g))     vld_q[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      last_q[idx] <= wr_last;
      hist_q[idx] <= wr_hist;
    end
  end

  assign rd_hit  = vld_q[idx];
  assign rd_last = last_q[idx];
  assign rd_hist = hist_q[idx];
endmodule

// File: rtl/mkv_pair_table.sv
module mkv_pair_table #(
  parameter int IDX_W   = 10,
  parameter int DELTA_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDX_W-1:0]   idx,
  input  logic               train_en,
  input  logic [DELTA_W-1:0] obs,
  output logic               rd_vld,
  output logic [DELTA_W-1:0] rd_d0,
  output logic [DELTA_W-1:0] rd_d1,
  output logic               rd_c0,
  output logic               rd_c1
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0]  vld_q, c0_q, c1_q;
  logic [DELTA_W-1:0]  d0_q [ENTRIES];
  logic [DELTA_W-1:0]  d1_q [ENTRIES];

  logic               hit0, hit1;
  logic [DELTA_W-1:0] d0_d, d1_d;
  logic               c0_d, c1_d;

  assign rd_vld = vld_q[idx];
  assign rd_d0  = d0_q[idx];
  assign rd_d1  = d1_q[idx];
  assign rd_c0  = c0_q[idx];
  assign rd_c1  = c1_q[idx];

  assign hit0 = rd_vld && (rd_d0 == obs);
  assign hit1 = rd_vld && !hit0 && (rd_d1 == obs);

  always_comb begin
    d0_d = rd_d0;
    d1_d = rd_d1;
    c0_d = rd_c0;
    c1_d = rd_c1;
    if (!rd_vld) begin
      d0_d = obs;
      d1_d = obs;
      c0_d = 1'b0;
      c1_d = 1'b0;
    end else if (hit0) begin
      c0_d = 1'b1;
    end else if (hit1) begin
      c1_d = 1'b1;
    end else if (!rd_c0) begin
      d0_d = obs;
      c0_d = 1'b0;
    end else begin
      d1_d = obs;
      c1_d = 1'b0;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_flags
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[g] <= 1'b0;
        c0_q[g]  <= 1'b0;
        c1_q[g]  <= 1'b0;
      end else if (train_en && idx == IDX_W'(g)) begin
        vld_q[g] <= 1'b1;
        c0_q[g]  <= c0_d;
        c1_q[g]  <= c1_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (train_en) begin
      d0_q[idx] <= d0_d;
      d1_q[idx] <= d1_d;
    end
  end
endmodule

// File: rtl/mkv_walker.sv
module mkv_walker
  import mkv_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DELTA_W = 16,
  parameter int DEPTH   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [ADDR_W-1:0]       start_base,
  input  logic [2:0][DELTA_W-1:0] start_hist,
  output logic [2:0][DELTA_W-1:0] walk_hist,
  input  logic                    rd_vld,
  input  logic [DELTA_W-1:0]      rd_d0,
  input  logic [DELTA_W-1:0]      rd_d1,
  input  logic                    rd_c0,
  input  logic                    rd_c1,
  output logic                    busy,
  output logic                    pf_valid,
  output logic [ADDR_W-1:0]       pf_addr
);
  localparam int STEP_W = $clog2(DEPTH + 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(DEPTH - 1);

  walk_state_e             state_q, state_d;
  logic [ADDR_W-1:0]       base_q, base_d;
  logic [2:0][DELTA_W-1:0] hist_q, hist_d;
  logic [STEP_W-1:0]       step_q, step_d;
  logic                    take0, take1, data_en;
  logic [DELTA_W-1:0]      next_delta;

  function automatic logic [ADDR_W-1:0] sx(input logic [DELTA_W-1:0] d);
    return {{(ADDR_W - DELTA_W){d[DELTA_W-1]}}, d};
  endfunction

  assign take0      = rd_vld && rd_c0;
  assign take1      = rd_vld && rd_c1;
  assign next_delta = take0 ? rd_d0 : rd_d1;

  always_comb begin
    state_d  = state_q;
    base_d   = base_q;
    hist_d   = hist_q;
    step_d   = step_q;
    data_en  = 1'b0;
    pf_valid = 1'b0;
    pf_addr  = base_q + sx(rd_d0);
    unique case (state_q)
      W_IDLE: begin
        if (start) begin
          state_d = W_SLOT0;
          base_d  = start_base;
          hist_d  = start_hist;
          step_d  = '0;
          data_en = 1'b1;
        end
      end
      W_SLOT0: begin
        pf_valid = take0;
        state_d  = W_SLOT1;
      end
      W_SLOT1: begin
        pf_valid = take1;
        pf_addr  = base_q + sx(rd_d1);
        if (!(take0 || take1) || step_q == LAST_STEP) begin
          state_d = W_IDLE;
        end else begin
          state_d = W_SLOT0;
          base_d  = base_q + sx(next_delta);
          hist_d  = {hist_q[1], hist_q[0], next_delta};
          step_d  = step_q + 1'b1;
          data_en = 1'b1;
        end
      end
      default: state_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= W_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (data_en) begin
      base_q <= base_d;
      hist_q <= hist_d;
      step_q <= step_d;
    end
  end

  assign walk_hist = hist_q;
  assign busy      = (state_q != W_IDLE);
endmodule

// File: rtl/delta_markov_prefetcher.sv
module delta_markov_prefetcher #(
  parameter int PC_W       = 32,
  parameter int ADDR_W     = 32,
  parameter int DELTA_W    = 16,
  parameter int HIST_IDX_W = 7,
  parameter int PAIR_IDX_W = 10,
  parameter int WALK_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [PC_W-1:0]   ev_pc,
  input  logic [ADDR_W-1:0] ev_addr,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr
);
  localparam int N_CHUNK = (PC_W + HIST_IDX_W - 1) / HIST_IDX_W;
  localparam int PC_EXT  = N_CHUNK * HIST_IDX_W;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [PC_EXT-1:0]                  pc_ext;
  logic [N_CHUNK:0][HIST_IDX_W-1:0]   pc_acc;
  assign pc_ext    = PC_EXT'(ev_pc);
  assign pc_acc[0] = '0;
  for (genvar c = 0; c < N_CHUNK; c++) begin : g_pcfold
    assign pc_acc[c+1] = pc_acc[c] ^ pc_ext[c*HIST_IDX_W +: HIST_IDX_W];
  end

  logic                    busy, accept, l1_hit;
  logic [DELTA_W-1:0]      l1_last, obs;
  logic [2:0][DELTA_W-1:0] l1_hist, new_hist, wr_hist, walk_hist;
  logic [PAIR_IDX_W-1:0]   train_idx, walk_idx, pair_idx;
  logic                    rd_vld, rd_c0, rd_c1;
  logic [DELTA_W-1:0]      rd_d0, rd_d1;

  assign ev_ready = rst_int_n && !busy;
  assign accept   = ev_valid && ev_ready;
  assign obs      = ev_addr[DELTA_W-1:0] - l1_last;
  assign new_hist = {l1_hist[1], l1_hist[0], obs};
  assign wr_hist  = l1_hit ? new_hist : '0;
  assign pair_idx = busy ? walk_idx : train_idx;

  mkv_hist_table #(.IDX_W(HIST_IDX_W), .DELTA_W(DELTA_W)) u_hist (
    .clk(clk), .rst_n(rst_int_n), .idx(pc_acc[N_CHUNK]),
    .rd_hit(l1_hit), .rd_last(l1_last), .rd_hist(l1_hist),
    .wr_en(accept), .wr_last(ev_addr[DELTA_W-1:0]), .wr_hist(wr_hist)
  );

  mkv_hash #(.DELTA_W(DELTA_W), .IDX_W(PAIR_IDX_W)) u_hash_train (
    .hist(l1_hist), .idx(train_idx)
  );

  mkv_hash #(.DELTA_W(DELTA_W), .IDX_W(PAIR_IDX_W)) u_hash_walk (
    .hist(walk_hist), .idx(walk_idx)
  );

  mkv_pair_table #(.IDX_W(PAIR_IDX_W), .DELTA_W(DELTA_W)) u_pair (
    .clk(clk), .rst_n(rst_int_n), .idx(pair_idx),
    .train_en(accept && l1_hit), .obs(obs),
    .rd_vld(rd_vld), .rd_d0(rd_d0), .rd_d1(rd_d1), .rd_c0(rd_c0), .rd_c1(rd_c1)
  );

  mkv_walker #(.ADDR_W(ADDR_W), .DELTA_W(DELTA_W), .DEPTH(WALK_DEPTH)) u_walk (
    .clk(clk), .rst_n(rst_int_n),
    .start(accept && l1_hit), .start_base(ev_addr), .start_hist(new_hist),
    .walk_hist(walk_hist),
    .rd_vld(rd_vld), .rd_d0(rd_d0), .rd_d1(rd_d1), .rd_c0(rd_c0), .rd_c1(rd_c1),
    .busy(busy), .pf_valid(pf_valid), .pf_addr(pf_addr)
  );
endmodule

// File: rtl/mkv_checker.sv
module mkv_checker #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_valid,
  input logic              ev_ready,
  input logic              hit,
  input logic              pf_valid,
  input logic [ADDR_W-1:0] pf_addr
);
  logic [7:0] pf_cnt_q, busy_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_cnt_q   <= '0;
      busy_cnt_q <= '0;
    end else begin
      if (ev_valid && ev_ready) pf_cnt_q <= '0;
      else if (pf_valid)        pf_cnt_q <= pf_cnt_q + 8'd1;
      if (ev_ready)             busy_cnt_q <= '0;
      else                      busy_cnt_q <= busy_cnt_q + 8'd1;
    end
  end

  // R9
  pf_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ready |-> !pf_valid);

  // R8
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_cnt_q <= 8'(2 * DEPTH));

  // R8
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt_q <= 8'(2 * DEPTH));

  // R2
  fresh_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ready && !hit) |=> ev_ready);

  // R7
  pf_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> !$isunknown(pf_addr));
endmodule

bind delta_markov_prefetcher mkv_checker #(.ADDR_W(ADDR_W), .DEPTH(WALK_DEPTH)) u_mkv_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
  .hit(l1_hit), .pf_valid(pf_valid), .pf_addr(pf_addr)
);

// File: tb/test_delta_markov_prefetcher.sv
module test_delta_markov_prefetcher;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ev_valid;
  logic        ev_ready;
  logic [31:0] ev_pc;
  logic [31:0] ev_addr;
  logic        pf_valid;
  logic [31:0] pf_addr;

  always #2 clk = ~clk;

  delta_markov_prefetcher i_delta_markov_prefetcher (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_pc(ev_pc), .ev_addr(ev_addr), .pf_valid(pf_valid), .pf_addr(pf_addr)
  );

  int total = 0;
  int fails = 0;
  bit mon_on = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  bit                l1v[int];
  logic [15:0]       l1last[int];
  logic [2:0][15:0]  l1h[int];
  bit                l2v[int];
  logic [15:0]       l2d0[int];
  logic [15:0]       l2d1[int];
  bit                l2c0[int];
  bit                l2c1[int];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int pc_fold(input logic [31:0] pc);
    logic [34:0] e;
    logic [6:0]  r;
    e = {3'b0, pc};
    r = '0;
    for (int c = 0; c < 5; c++) r ^= e[c*7 +: 7];
    return int'(r);
  endfunction

  function automatic int hsh(input logic [2:0][15:0] h);
    logic [19:0] e;
    logic [9:0]  f, r;
    r = '0;
    for (int a = 0; a < 3; a++) begin
      e = {4'b0, h[a]};
      f = e[9:0] ^ e[19:10];
      r ^= 10'(f << a);
    end
    return int'(r);
  endfunction

  function automatic logic [31:0] sx(input logic [15:0] d);
    return {{16{d[15]}}, d};
  endfunction

  task automatic train(input int t, input logic [15:0] obs);
    if (!l2v.exists(t)) begin
      l2v[t] = 1; l2d0[t] = obs; l2d1[t] = obs; l2c0[t] = 0; l2c1[t] = 0;
    end else if (l2d0[t] == obs) l2c0[t] = 1;
    else if (l2d1[t] == obs)     l2c1[t] = 1;
    else if (!l2c0[t]) begin l2d0[t] = obs; l2c0[t] = 0; end
    else begin l2d1[t] = obs; l2c1[t] = 0; end
  endtask

  task automatic walk(input logic [31:0] base_in, input logic [2:0][15:0] h_in, input string tag);
    logic [31:0]      base;
    logic [2:0][15:0] h;
    logic [15:0]      nd;
    int               t;
    base = base_in;
    h = h_in;
    for (int s = 0; s < 4; s++) begin
      t = hsh(h);
      if (!l2v.exists(t)) break;
      if (l2c0[t]) begin exp_q.push_back(base + sx(l2d0[t])); tag_q.push_back({tag, " R7 R4 slot0"}); end
      if (l2c1[t]) begin exp_q.push_back(base + sx(l2d1[t])); tag_q.push_back({tag, " R7 R4 slot1"}); end
      if (!(l2c0[t] || l2c1[t])) break;
      nd = l2c0[t] ? l2d0[t] : l2d1[t];
      base = base + sx(nd);
      h = {h[1], h[0], nd};
    end
  endtask

  task automatic model(input logic [31:0] pc, input logic [31:0] addr, input string tag);
    int k;
    logic [15:0]      obs;
    logic [2:0][15:0] h, nh;
    k = pc_fold(pc);
    if (!l1v.exists(k)) begin
      l1v[k] = 1; l1last[k] = addr[15:0]; l1h[k] = '0;
      return;
    end
    h = l1h[k];
    obs = addr[15:0] - l1last[k];
    train(hsh(h), obs);
    nh = {h[1], h[0], obs};
    l1h[k] = nh;
    l1last[k] = addr[15:0];
    walk(addr, nh, tag);
  endtask

  // driver: model first, then offer the event and wait for the walk to end
  task automatic send(input logic [31:0] pc, input logic [31:0] addr, input string tag);
    model(pc, addr, tag);
    @(negedge clk);
    while (!ev_ready) @(negedge clk);
    ev_valid = 1'b1; ev_pc = pc; ev_addr = addr;
    @(negedge clk);
    ev_valid = 1'b0;
    while (!ev_ready) @(negedge clk);
    chk(exp_q.size() == 0, {tag, " R8 burst complete"}, 32'(exp_q.size()), 32'd0);
    exp_q.delete();
    tag_q.delete();
  endtask

  task automatic run_seq(input logic [31:0] pc, input logic [31:0] start, input logic [31:0] step,
                         input int n, input string tag);
    logic [31:0] a;
    a = start;
    for (int i = 0; i < n; i++) begin
      send(pc, a, tag);
      a = a + step;
    end
  endtask

  // monitor: pop and compare every prefetch
  always @(negedge clk) begin
    if (mon_on && pf_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected prefetch", pf_addr, 32'hxxxxxxxx);
      end else begin
        chk(pf_addr === exp_q[0], tag_q[0], pf_addr, exp_q[0]);
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] a;
    rst_n = 1'b0; ev_valid = 1'b0; ev_pc = '0; ev_addr = '0;
    repeat (4) @(negedge clk);
    chk(!ev_ready && !pf_valid, "R1 in reset", {30'd0, ev_ready, pf_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ev_ready, "R1 sync release", {31'd0, ev_ready}, 32'd0);
    repeat (2) @(negedge clk);
    chk(ev_ready && !pf_valid, "R1 idle after reset", {30'd0, ev_ready, pf_valid}, 32'd2);
    mon_on = 1'b1;

    // R2 first event, then R5 constant stride trains slot 0 and R8 walks full depth
    run_seq(32'h400, 32'h0001_0000, 32'h40, 10, "R2 R3 R5 stride");
    // R2 alias PC folding to the same slot continues that history
    send(32'h481, 32'h0001_0280, "R2 alias");
    // R10 another load shares the trained transitions
    run_seq(32'h800, 32'h0005_0000, 32'h40, 6, "R10 shared");
    // R5 alternating deltas confirm slot 1 and walk follows alternately
    a = 32'h0002_0000;
    for (int i = 0; i < 12; i++) begin
      send(32'h404, a, "R5 R8 alternating");
      a = a + ((i % 2 == 0) ? 32'h40 : 32'h100);
    end
    // R6 fixed history followed by changing deltas forces replacement
    a = 32'h0003_0000;
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 4; i++) begin
        send(32'h408, a, "R6 replace");
        a = a + 32'h20;
      end
      a = a + ((r == 2) ? 32'h200 : 32'h60) - 32'h20;
      send(32'h408, a, "R6 replace");
    end
    run_seq(32'h408, a + 32'h20, 32'h20, 5, "R6 recover");
    // R7 negative stride needs sign extension
    run_seq(32'h40C, 32'h0004_0000, 32'hFFFF_FF80, 8, "R7 falling");
    // R3 jumps wider than the delta field
    run_seq(32'h410, 32'h0010_0000, 32'h0003_1000, 7, "R3 truncate");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0 && ev_ready, "R9 final idle", 32'(exp_q.size()), 32'd0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule